// File: doc/BRIEF.md
# Partial-Scan State Bank

This block holds a bank of state flip-flops, of which a subset chosen at compile time by a bit mask is made testable by shifting. The masked bits, the scan cells, form one serial chain. The remaining bits are plain data flip-flops with no serial path. The two groups are clocked from separate enables, which stand in for two clocks. The scan group can therefore shift a test pattern in and a captured response out while the plain group keeps its contents.

In functional operation both enables are held high and every bit loads its next-state input. To prepare a test, the scan enable alone is pulsed with test control low. Each pulse moves the chain one place toward the serial output. A single pulse with test control high captures the functional next state into the scan cells. The block has only plain control and data pins. It uses no handshake, and an enable that is low simply means no load on that edge.

Top module: `partial_scan_bank`

## Requirements
- R1: While `rst_n` is low, every bit of `state_q` is 0 and `scan_out` is 0.
- R2: On a clock edge with `scan_en`=1 and `test_ctl`=1, every scan cell loads its bit of `func_d`.
- R3: On a clock edge with `core_en`=1, every non-scan bit loads its bit of `func_d`, whatever the values of `test_ctl` and `scan_en`.
- R4: On a clock edge with `core_en`=0, every non-scan bit keeps its value, even while the scan cells shift or capture.
- R5: On a clock edge with `scan_en`=0, every scan cell keeps its value.
- R6: On a clock edge with `scan_en`=1 and `test_ctl`=0 (shift), the lowest-index scan cell loads `scan_in`. Every other scan cell loads the old value of the nearest scan cell below it in bit index. Non-scan bits between two scan cells add no delay.
- R7: `scan_out` equals the current value of the highest-index scan cell, with no extra register stage.
- R8: With an all-zero mask, `scan_out` is constant 0, and `scan_in`, `scan_en` and `test_ctl` have no effect on `state_q`.
- R9: With an all-ones mask, all bits form one chain. A value applied at `scan_in` appears on `scan_out` after as many shift edges as there are bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for every bit |
| rst_n | input | 1 | Asynchronous active-low reset, clears all bits |
| test_ctl | input | 1 | Scan-cell mode: 1 = functional capture, 0 = serial shift |
| scan_en | input | 1 | Load enable for the scan cells (scan clock) |
| core_en | input | 1 | Load enable for the non-scan bits (non-scan clock) |
| func_d | input | WIDTH | Functional next-state data |
| scan_in | input | 1 | Serial input to the lowest-index scan cell |
| state_q | output | WIDTH | Current state of all bits |
| scan_out | output | 1 | Serial output, value of the highest-index scan cell |

## Verification
The bench focuses on shifts in which `core_en` is low. A design that let the plain bits follow `func_d` there, or that gated them with `test_ctl`, would corrupt state that partial scan must keep. It also drives a default mask with gaps, checking that non-scan bits inside the chain are skipped. A design that routed the chain through every bit would show the pattern late and in the wrong places. Two extra instances cover the all-zero and all-ones masks: a leaking serial path would show as a nonzero `scan_out` in the first, and a wrong chain length would show as a misaligned `scan_out` stream in the second.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int MAX_W = 64;

  function automatic int scan_count(input logic [MAX_W-1:0] m, input int w);
    int n = 0;
    for (int i = 0; i < w; i++) if (m[i]) n++;
    return n;
  endfunction

  function automatic int scan_first(input logic [MAX_W-1:0] m, input int w);
    int r = -1;
    for (int i = w - 1; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  function automatic int scan_last(input logic [MAX_W-1:0] m, input int w);
    int r = -1;
    for (int i = 0; i < w; i++) if (m[i]) r = i;
    return r;
  endfunction

  // nearest masked index strictly below pos, -1 if none
  function automatic int scan_prev(input logic [MAX_W-1:0] m, input int pos);
    int r = -1;
    for (int i = 0; i < pos; i++) if (m[i]) r = i;
    return r;
  endfunction
endpackage

// File: rtl/psr_scan_cell.sv
module psr_scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic capture,
  input  logic d,
  input  logic si,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (en)  q <= capture ? d : si;
  end
endmodule

// File: rtl/psr_hold_cell.sv
module psr_hold_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/partial_scan_bank.sv
module partial_scan_bank #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] SCAN_MASK = 8'b1011_0110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             test_ctl,
  input  logic             scan_en,
  input  logic             core_en,
  input  logic [WIDTH-1:0] func_d,
  input  logic             scan_in,
  output logic [WIDTH-1:0] state_q,
  output logic             scan_out
);
  localparam int NSCAN = psr_pkg::scan_count(64'(SCAN_MASK), WIDTH);

  // link[i] is the serial value seen by bit i: scan_in or the nearest lower scan cell
  logic [WIDTH:0] link;
  assign link[0] = scan_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (SCAN_MASK[i]) begin : g_scan
      psr_scan_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (scan_en),
        .capture (test_ctl),
        .d       (func_d[i]),
        .si      (link[i]),
        .q       (state_q[i])
      );
      assign link[i+1] = state_q[i];
    end else begin : g_plain
      psr_hold_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (core_en),
        .d     (func_d[i]),
        .q     (state_q[i])
      );
      assign link[i+1] = link[i];
    end
  end

  if (NSCAN > 0) begin : g_out
    assign scan_out = link[WIDTH];
  end else begin : g_noout
    assign scan_out = 1'b0;
  end
endmodule

// File: rtl/psr_bank_checker.sv
module psr_bank_checker #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] SCAN_MASK = 8'b1011_0110
) (
  input logic             clk,
  input logic             rst_n,
  input logic             test_ctl,
  input logic             scan_en,
  input logic             core_en,
  input logic [WIDTH-1:0] func_d,
  input logic             scan_in,
  input logic [WIDTH-1:0] state_q,
  input logic             scan_out
);
  localparam int FIRST = psr_pkg::scan_first(64'(SCAN_MASK), WIDTH);
  localparam int LAST  = psr_pkg::scan_last(64'(SCAN_MASK), WIDTH);
  localparam logic [WIDTH-1:0] PLAIN = ~SCAN_MASK;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && test_ctl) |=> ((state_q & SCAN_MASK) == ($past(func_d) & SCAN_MASK)));

  p_core_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |=> ((state_q & PLAIN) == ($past(func_d) & PLAIN)));

  p_core_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> $stable(state_q & PLAIN));

  p_scan_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(state_q & SCAN_MASK));

  if (FIRST >= 0) begin : g_chain
    p_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en && !test_ctl) |=> (state_q[FIRST] == $past(scan_in)));

    p_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
      scan_out == state_q[LAST]);

    for (genvar i = 0; i < WIDTH; i++) begin : g_link
      if (SCAN_MASK[i] && i != FIRST) begin : g_on
        localparam int P = psr_pkg::scan_prev(64'(SCAN_MASK), i);
        p_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
          (scan_en && !test_ctl) |=> (state_q[i] == $past(state_q[P])));
      end
    end
  end
endmodule

bind partial_scan_bank psr_bank_checker #(.WIDTH(WIDTH), .SCAN_MASK(SCAN_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_ctl(test_ctl), .scan_en(scan_en),
  .core_en(core_en), .func_d(func_d), .scan_in(scan_in),
  .state_q(state_q), .scan_out(scan_out)
);

// File: tb/partial_scan_bank_test.sv
`timescale 1ns/1ps
module partial_scan_bank_test;
  localparam int W = 8;
  localparam logic [W-1:0] M_DEF  = 8'b1011_0110;
  localparam logic [W-1:0] M_FULL = 8'hFF;
  localparam logic [W-1:0] M_NONE = 8'h00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_ctl = 1'b0, scan_en = 1'b0, core_en = 1'b0, scan_in = 1'b0;
  logic [W-1:0] func_d = '0;
  logic [W-1:0] q_def, q_full, q_none;
  logic so_def, so_full, so_none;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  partial_scan_bank #(.WIDTH(W), .SCAN_MASK(M_DEF)) uut (
    .clk(clk), .rst_n(rst_n), .test_ctl(test_ctl), .scan_en(scan_en), .core_en(core_en),
    .func_d(func_d), .scan_in(scan_in), .state_q(q_def), .scan_out(so_def));
  partial_scan_bank #(.WIDTH(W), .SCAN_MASK(M_FULL)) u_full (
    .clk(clk), .rst_n(rst_n), .test_ctl(test_ctl), .scan_en(scan_en), .core_en(core_en),
    .func_d(func_d), .scan_in(scan_in), .state_q(q_full), .scan_out(so_full));
  partial_scan_bank #(.WIDTH(W), .SCAN_MASK(M_NONE)) u_none (
    .clk(clk), .rst_n(rst_n), .test_ctl(test_ctl), .scan_en(scan_en), .core_en(core_en),
    .func_d(func_d), .scan_in(scan_in), .state_q(q_none), .scan_out(so_none));

  // reference model: scan cells gathered into a queue in chain order
  logic [W-1:0] m_def = '0, m_full = '0, m_none = '0;
  bit in_reset = 1'b1;
  bit l_tc, l_se, l_ce;

  function automatic logic [W-1:0] model_step(logic [W-1:0] m, logic [W-1:0] s,
      logic [W-1:0] d, bit tc, bit se, bit ce, bit si);
    logic [W-1:0] n = s;
    bit chain[$];
    int k = 0;
    if (se) begin
      if (tc) begin
        for (int i = 0; i < W; i++) if (m[i]) n[i] = d[i];
      end else begin
        for (int i = 0; i < W; i++) if (m[i]) chain.push_back(s[i]);
        chain.push_front(si);
        void'(chain.pop_back());
        for (int i = 0; i < W; i++) if (m[i]) begin n[i] = chain[k]; k++; end
      end
    end
    if (ce) for (int i = 0; i < W; i++) if (!m[i]) n[i] = d[i];
    return n;
  endfunction

  function automatic bit model_out(logic [W-1:0] m, logic [W-1:0] s);
    bit chain[$];
    for (int i = 0; i < W; i++) if (m[i]) chain.push_back(s[i]);
    if (chain.size() == 0) return 1'b0;
    return chain[chain.size()-1];
  endfunction

  task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    string ts, tp;
    if (in_reset) begin ts = "R1"; tp = "R1"; end
    else begin
      ts = !l_se ? "R5" : (l_tc ? "R2" : "R6");
      tp = l_ce ? "R3" : "R4";
    end
    cmp(ts, "scan bits", q_def & M_DEF, m_def & M_DEF);
    cmp(tp, "plain bits", q_def & ~M_DEF, m_def & ~M_DEF);
    cmp(in_reset ? "R1" : "R7", "scan_out", {7'b0, so_def}, {7'b0, model_out(M_DEF, m_def)});
    cmp("R9", "full state", q_full, m_full);
    cmp("R9", "full scan_out", {7'b0, so_full}, {7'b0, model_out(M_FULL, m_full)});
    cmp("R8", "empty state", q_none, m_none);
    cmp("R8", "empty scan_out", {7'b0, so_none}, 8'h00);
  endtask

  // called at a falling edge; result is checked at the next falling edge
  task automatic step(logic [W-1:0] d, bit tc, bit se, bit ce, bit si);
    logic [W-1:0] n_def, n_full, n_none;
    func_d = d; test_ctl = tc; scan_en = se; core_en = ce; scan_in = si;
    l_tc = tc; l_se = se; l_ce = ce;
    n_def  = model_step(M_DEF,  m_def,  d, tc, se, ce, si);
    n_full = model_step(M_FULL, m_full, d, tc, se, ce, si);
    n_none = model_step(M_NONE, m_none, d, tc, se, ce, si);
    @(posedge clk);
    m_def = n_def; m_full = n_full; m_none = n_none;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    check_all();
    rst_n = 1'b1;
    in_reset = 1'b0;

    // R2/R3: functional capture on both groups
    step(8'hA5, 1, 1, 1, 0);
    // R6/R4: shift 0011 pattern, plain bits must hold against changing data
    for (int t = 0; t < 5 + 4; t++) step(8'hFF ^ 8'(t), 0, 1, 0, (t % 4) >= 2);
    // R9: walk a single one through the full chain
    step(8'h00, 0, 1, 0, 1);
    for (int t = 0; t < W; t++) step(8'h5A, 0, 1, 0, 0);
    // R2 with plain clock off
    step(8'h3C, 1, 1, 0, 0);
    // R3 with scan clock off, test_ctl low
    step(8'hC3, 0, 0, 1, 1);
    // R5/R4: everything idle
    step(8'h99, 1, 0, 0, 1);
    // R8: scan activity only, empty mask must stay put
    for (int t = 0; t < 6; t++) step(8'(t * 37), t[0], 1, 0, ~t[0]);
    // mixed random traffic
    for (int t = 0; t < 400; t++) begin
      logic [31:0] r = $urandom;
      step(r[7:0], r[8], r[9], r[10], r[11]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule